// File: doc/BRIEF.md
# Time-Interleaved Interaction Scheduler

This block wraps one physical pair-interaction pipeline so that it can serve several target particles at once. A small register file holds `NSLOT` target operands and a matching file holds `NSLOT` running sums. When a source particle is taken in, the scheduler presents it to the pipeline on `NSLOT` consecutive clocks, once for each target slot. Each fetched source word is therefore used `NSLOT` times, and the source stream needs only one word every `NSLOT` cycles. Several such blocks can sit on one broadcast source stream, each holding its own targets.

The interaction is a fixed-latency placeholder: the product of target and source, delayed by `LAT` register stages. The slot number travels down the pipeline next to the data. Each result is therefore added to the sum it belongs to, even though the issue counter has moved on by the time the result arrives. The host loads targets while the block is idle, clears the sums, streams sources, waits for `busy` to fall, and then reads any sum through the readout port.

The source input is a valid/ready stream. A word transfers on a clock edge where both `src_valid` and `src_ready` are high. Once the sender raises `src_valid` it holds the signal and `src_data` until the transfer. `src_data` is ignored on every cycle without a transfer. Target loading, clear, readout and `busy` are plain pins.

Top module: `vmp_sched`

## Requirements
- R1: After reset, `src_ready` is 1, `busy` is 0, and every slot reads 0 on `rd_data`.
- R2: When `tgt_we` is high, the value on `tgt_data` is stored into target slot `tgt_slot` at the clock edge. All sources issued after that edge use the new value.
- R3: `src_ready` is high when no source is held, or when the held source is in its last slot cycle (slot `NSLOT-1`). In the cycle after a transfer, `src_ready` is low. With `src_valid` held high continuously, transfers occur exactly `NSLOT` cycles apart. They are never closer together than that.
- R4: Each accepted source value s adds tgt[k]*s, modulo 2^AW, to the sum of every slot k exactly once. Here tgt[k] is the unsigned target value and the product is 2*DW bits wide.
- R5: The sums are updated in slot order. If a transfer happens at edge E0, the contribution to slot k is written at edge E0+LAT+1+k.
- R6: When `acc_clr` is high at an edge, every sum becomes 0. A write-back that falls on the same edge is discarded. Write-backs on later edges add onto zero.
- R7: `rd_data` shows the sum of slot `rd_slot` combinationally, for any slot.
- R8: After the last transfer at edge E0, `busy` stays high through edge E0+LAT+NSLOT-1 and is low after edge E0+LAT+NSLOT. From that point all sums are final.
- R9: The value of `src_data` on cycles without a transfer has no effect on any sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_we | input | 1 | Target write strobe |
| tgt_slot | input | SW | Target slot to write |
| tgt_data | input | DW | Target operand value |
| src_valid | input | 1 | Source word offered |
| src_ready | output | 1 | Scheduler can take a source word |
| src_data | input | DW | Source operand value |
| acc_clr | input | 1 | Zero all sums |
| rd_slot | input | SW | Slot selected for readout |
| rd_data | output | AW | Sum of the selected slot |
| busy | output | 1 | Source held or results still in the pipeline |

## Verification
Clearing the sums and a pipeline write-back can fall on the same edge. The bench provokes this on purpose: it takes in one source and raises `acc_clr` on the edge where slot 1's contribution lands. By R5 and R6, the expected result is that slots 0 and 1 read zero while slots 2 and 3 hold their single products. A second overlap is a new transfer in the same cycle as the last slot issue of the previous source. Back-to-back streaming with no stalls exercises it. The bench checks this through exact transfer spacing and through per-slot sums computed arithmetically from the target values and the accepted source words.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
  localparam int DEF_NSLOT = 4;
  localparam int DEF_DW    = 8;
  localparam int DEF_AW    = 32;
  localparam int DEF_LAT   = 3;
endpackage

// File: rtl/vmp_issue.sv
module vmp_issue #(
  parameter int NSLOT = 4,
  parameter int DW    = 8,
  parameter int SW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          src_ready,
  output logic          iss_valid,
  output logic [SW-1:0] iss_slot,
  output logic [DW-1:0] iss_src
);
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

  logic          active;
  logic [SW-1:0] cnt;
  logic [DW-1:0] hold;
  logic          at_last;
  logic          take;

  assign at_last   = (cnt == LAST);
  assign src_ready = !active || at_last;
  assign take      = src_valid && src_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      hold   <= '0;
    end else if (take) begin
      active <= 1'b1;
      cnt    <= '0;
      hold   <= src_data;
    end else if (active) begin
      if (at_last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign iss_valid = active;
  assign iss_slot  = cnt;
  assign iss_src   = hold;
endmodule

// File: rtl/vmp_interact.sv
module vmp_interact #(
  parameter int DW  = 8,
  parameter int SW  = 2,
  parameter int LAT = 3,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_slot,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  output logic [SW-1:0] out_slot,
  output logic [PW-1:0] out_val,
  output logic          inflight
);
  logic [LAT-1:0] v_q;
  logic [SW-1:0]  s_q [LAT];
  logic [PW-1:0]  p_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
      s_q[0] <= '0;
      p_q[0] <= '0;
    end else begin
      v_q[0] <= in_valid;
      s_q[0] <= in_slot;
      p_q[0] <= PW'(in_a) * PW'(in_b);
    end
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[g] <= 1'b0;
        s_q[g] <= '0;
        p_q[g] <= '0;
      end else begin
        v_q[g] <= v_q[g-1];
        s_q[g] <= s_q[g-1];
        p_q[g] <= p_q[g-1];
      end
    end
  end

  assign out_valid = v_q[LAT-1];
  assign out_slot  = s_q[LAT-1];
  assign out_val   = p_q[LAT-1];
  assign inflight  = |v_q;
endmodule

// File: rtl/vmp_accum.sv
module vmp_accum #(
  parameter int NSLOT = 4,
  parameter int SW    = 2,
  parameter int PW    = 16,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wb_valid,
  input  logic [SW-1:0] wb_slot,
  input  logic [PW-1:0] wb_val,
  input  logic [SW-1:0] rd_slot,
  output logic [AW-1:0] rd_data
);
  logic [AW-1:0] acc [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        acc[g] <= '0;
      end else if (wb_valid && wb_slot == SW'(g)) begin
        acc[g] <= acc[g] + AW'(wb_val);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (rd_slot == SW'(i)) rd_data = acc[i];
    end
  end
endmodule

// File: rtl/vmp_sched.sv
module vmp_sched #(
  parameter int NSLOT = vmp_pkg::DEF_NSLOT,
  parameter int DW    = vmp_pkg::DEF_DW,
  parameter int AW    = vmp_pkg::DEF_AW,
  parameter int LAT   = vmp_pkg::DEF_LAT,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int PW   = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tgt_we,
  input  logic [SW-1:0] tgt_slot,
  input  logic [DW-1:0] tgt_data,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [DW-1:0] src_data,
  input  logic          acc_clr,
  input  logic [SW-1:0] rd_slot,
  output logic [AW-1:0] rd_data,
  output logic          busy
);
  logic [DW-1:0] tgt_q [NSLOT];
  logic          iss_valid;
  logic [SW-1:0] iss_slot;
  logic [DW-1:0] iss_src;
  logic [DW-1:0] iss_tgt;
  logic          wb_valid;
  logic [SW-1:0] wb_slot;
  logic [PW-1:0] wb_val;
  logic          inflight;

  for (genvar g = 0; g < NSLOT; g++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (!rst_n) tgt_q[g] <= '0;
      else if (tgt_we && tgt_slot == SW'(g)) tgt_q[g] <= tgt_data;
    end
  end

  always_comb begin
    iss_tgt = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (iss_slot == SW'(i)) iss_tgt = tgt_q[i];
    end
  end

  vmp_issue #(.NSLOT(NSLOT), .DW(DW), .SW(SW)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_src(iss_src)
  );

  vmp_interact #(.DW(DW), .SW(SW), .LAT(LAT)) u_interact (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iss_valid), .in_slot(iss_slot), .in_a(iss_tgt), .in_b(iss_src),
    .out_valid(wb_valid), .out_slot(wb_slot), .out_val(wb_val),
    .inflight(inflight)
  );

  vmp_accum #(.NSLOT(NSLOT), .SW(SW), .PW(PW), .AW(AW)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr),
    .wb_valid(wb_valid), .wb_slot(wb_slot), .wb_val(wb_val),
    .rd_slot(rd_slot), .rd_data(rd_data)
  );

  assign busy = iss_valid || inflight;
endmodule

// File: rtl/vmp_sched_chk.sv
module vmp_sched_chk #(
  parameter int NSLOT = 4,
  parameter int SW    = 2,
  parameter int AW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          src_valid,
  input logic          src_ready,
  input logic          acc_clr,
  input logic [AW-1:0] rd_data,
  input logic          busy,
  input logic          iss_valid,
  input logic [SW-1:0] iss_slot
);
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

  // R3
  ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> !src_ready);

  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_slot != LAST) |=> (iss_valid && iss_slot == SW'($past(iss_slot) + 1'b1)));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (rd_data == '0));

  // R8
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> src_ready);

  // R3
  start_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> (iss_valid && iss_slot == '0));
endmodule

bind vmp_sched vmp_sched_chk #(.NSLOT(NSLOT), .SW(SW), .AW(AW)) u_vmp_sched_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
  .acc_clr(acc_clr), .rd_data(rd_data), .busy(busy),
  .iss_valid(iss_valid), .iss_slot(iss_slot)
);

// File: tb/vmp_sched_bench.sv
module vmp_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 4;
  localparam int DW = 8;
  localparam int AW = 32;
  localparam int LAT = 3;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tgt_we = 1'b0;
  logic [SW-1:0] tgt_slot = '0;
  logic [DW-1:0] tgt_data = '0;
  logic src_valid = 1'b0;
  logic src_ready;
  logic [DW-1:0] src_data = '0;
  logic acc_clr = 1'b0;
  logic [SW-1:0] rd_slot = '0;
  logic [AW-1:0] rd_data;
  logic busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW-1:0] tg [NSLOT];
  logic [AW-1:0] expv [NSLOT];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vmp_sched #(.NSLOT(NSLOT), .DW(DW), .AW(AW), .LAT(LAT)) u_vmp_sched (
    .clk(clk), .rst_n(rst_n), .tgt_we(tgt_we), .tgt_slot(tgt_slot), .tgt_data(tgt_data),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .acc_clr(acc_clr), .rd_slot(rd_slot), .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  task automatic load_targets();
    for (int k = 0; k < NSLOT; k++) begin
      @(negedge clk);
      tgt_we = 1'b1; tgt_slot = SW'(k); tgt_data = tg[k];
    end
    @(negedge clk);
    tgt_we = 1'b0;
  endtask

  task automatic clear_sums();
    @(negedge clk);
    acc_clr = 1'b1;
    @(negedge clk);
    acc_clr = 1'b0;
    for (int k = 0; k < NSLOT; k++) expv[k] = '0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_sums(input string req);
    for (int k = 0; k < NSLOT; k++) begin
      rd_slot = SW'(k);
      #1;
      chk(rd_data == expv[k], req, rd_data, expv[k]);
    end
  endtask

  // dmode: 0 random data, 1 all ones, 2 zero
  task automatic stream(input int n, input int stall_pct, input int dmode, input string req);
    int sent = 0;
    int last_acc = -1;
    bit pend = 1'b0;
    bit gap_ok = 1'b1;
    int bad_gap = 0;
    while (sent < n) begin
      @(negedge clk);
      if (!pend) begin
        if ($urandom_range(99) < stall_pct) begin
          src_valid = 1'b0;
          src_data = DW'($urandom);
        end else begin
          src_valid = 1'b1;
          pend = 1'b1;
          src_data = (dmode == 1) ? '1 : (dmode == 2) ? '0 : DW'($urandom);
        end
      end
      #(CLK_PERIOD/2 - 1);
      if (src_valid && src_ready) begin
        for (int k = 0; k < NSLOT; k++)
          expv[k] = expv[k] + AW'(32'(tg[k]) * 32'(src_data));
        if (last_acc >= 0) begin
          if (stall_pct == 0 && cyc - last_acc != NSLOT) begin gap_ok = 0; bad_gap = cyc - last_acc; end
          if (cyc - last_acc < NSLOT) begin gap_ok = 0; bad_gap = cyc - last_acc; end
        end
        last_acc = cyc;
        sent++;
        pend = 1'b0;
      end
    end
    @(negedge clk);
    src_valid = 1'b0;
    // R3 transfer spacing
    chk(gap_ok, "R3 spacing", bad_gap, NSLOT);
    wait_idle();
    check_sums(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(src_ready == 1'b1, "R1 ready", src_ready, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    for (int k = 0; k < NSLOT; k++) expv[k] = '0;
    check_sums("R1 sums");

    // R2 R4: distinct targets, back-to-back sources
    tg[0] = 8'd1; tg[1] = 8'd2; tg[2] = 8'd3; tg[3] = 8'd250;
    load_targets();
    clear_sums();
    stream(20, 0, 0, "R4 back-to-back");

    // R9 random stalls, garbage data on idle cycles
    clear_sums();
    stream(40, 50, 0, "R9 stalls");

    // R2 reload targets; max operand boundary
    tg[0] = 8'hFF; tg[1] = 8'h00; tg[2] = 8'h80; tg[3] = 8'h7F;
    load_targets();
    clear_sums();
    stream(16, 20, 1, "R2 reload max");

    // R4 zero sources do not disturb sums (no clear in between)
    stream(8, 30, 2, "R4 zero sources");

    // R6 sweep of random target sets
    for (int rep = 0; rep < 4; rep++) begin
      for (int k = 0; k < NSLOT; k++) tg[k] = DW'($urandom);
      load_targets();
      clear_sums();
      stream(25, rep * 20, 0, "R4 random set");
    end

    // R5 R6 R8: clear collides with slot 1 write-back; busy timing
    tg[0] = 8'd3; tg[1] = 8'd5; tg[2] = 8'd7; tg[3] = 8'd11;
    load_targets();
    clear_sums();
    @(negedge clk);
    src_valid = 1'b1; src_data = 8'd13;
    @(posedge clk);              // E0 transfer
    @(negedge clk);
    src_valid = 1'b0;
    repeat (3) @(posedge clk);   // E1..E3
    @(posedge clk);              // E4: slot 0 write-back
    @(negedge clk);
    rd_slot = '0; #1;
    chk(rd_data == 32'd39, "R5 slot0 timing", rd_data, 39);
    acc_clr = 1'b1;
    @(posedge clk);              // E5: clear with slot 1 write-back
    @(negedge clk);
    acc_clr = 1'b0;
    @(posedge clk);              // E6
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy held", busy, 1);
    @(posedge clk);              // E7 last write-back
    @(negedge clk);
    chk(busy == 1'b0, "R8 busy falls", busy, 0);
    expv[0] = 0; expv[1] = 0; expv[2] = 32'd91; expv[3] = 32'd143;
    check_sums("R6 clear collision");

    // R7 readout of every slot with several select changes
    for (int k = NSLOT - 1; k >= 0; k--) begin
      rd_slot = SW'(k); #1;
      chk(rd_data == expv[k], "R7 readout", rd_data, expv[k]);
    end

    finish_run();
  end
endmodule